// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces horizontal sync, vertical sync, display enable and a blank indication for a raster display. The pixel and line position counters are 16-bit linear feedback shift registers rather than binary adders. Each counter step is therefore a shift plus a four-input XOR, and the carry chain of a binary counter disappears. Every terminal, sync edge and window edge is found by an equality compare against the register state that the counter reaches after the wanted number of steps.

Software programs ordinary binary numbers: totals, active sizes, sync start positions and sync lengths. On a load pulse the block latches them and derives eight position values. A built-in converter turns each value N into the shift-register state reached after N steps by running the register N times from all ones. When all eight states are stored, the block raises ready and starts scanning from position zero. Sync and display windows are placed relative to the start of sync. A two-bit blank mode selects normal output, blanked video with running syncs, or power-down.

Top module: `lfsr_vtg`

## Requirements
- R1: While reset is asserted, and until the first configuration completes, hsync_o, vsync_o, de_o and ready_o are 0 and blank_o is 1.
- R2: Each position register steps by shifting left one bit and inserting the XOR of old bits 15, 4, 2 and 1, starting from 16'hFFFF. After a load_i pulse, ready_o rises within (sum of the eight derived counts) + 28 cycles. The eight derived counts are htotal-1, hsync_len+1, htotal-hsync_start, htotal-hsync_start+hactive, vtotal, vsync_len, vtotal-vsync_start and vtotal-vsync_start+vactive.
- R3: A line lasts htotal_i cycles. Pixel position h runs 0..htotal-1, and h=0 is the first cycle with ready_o high.
- R4: hsync_o is high exactly when 2 <= h <= hsync_len+1.
- R5: The horizontal display window is high exactly when ds+1 <= h <= ds+hactive, where ds = htotal-hsync_start. This requires hactive < hsync_start.
- R6: A frame lasts vtotal_i lines. Line index v runs 0..vtotal-1 and advances when h wraps.
- R7: vsync_o is high during lines 1 <= v <= vsync_len.
- R8: de_o is high only when both the horizontal window and the vertical window (vds+1 <= v <= vds+vactive, vds = vtotal-vsync_start) are high. This requires vactive < vsync_start.
- R9: blank_mode_i = 2'b01 forces de_o low while both syncs and both counters keep running. blank_mode_i = 2'b00 is normal output.
- R10: blank_mode_i[1] = 1 selects power-down. All three outputs go low and both counters are held at position 0. On return to 2'b00, scanning resumes with h=1, v=0 one cycle later.
- R11: blank_o is always the inverse of de_o.
- R12: A load_i pulse while scanning drops ready_o on the next cycle. Scanning then restarts at position 0 with the new timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Latch the timing inputs and reprogram |
| htotal_i | input | TW | Pixels per line |
| hactive_i | input | TW | Visible pixels per line |
| hsync_start_i | input | TW | Pixel position of horizontal sync start |
| hsync_len_i | input | TW | Horizontal sync length in pixels |
| vtotal_i | input | TW | Lines per frame |
| vactive_i | input | TW | Visible lines per frame |
| vsync_start_i | input | TW | Line position of vertical sync start |
| vsync_len_i | input | TW | Vertical sync length in lines |
| blank_mode_i | input | 2 | 00 normal, 01 blanked video, 1x power-down |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blank indication, inverse of de_o |
| ready_o | output | 1 | Timing programmed and scanning |

## Verification
The syncs and window flags are registered one clock after the counter state that sets them. This is why a window set at count s is first seen at s+1. The bench builds its expected outputs on that one-cycle offset. Position zero is taken as the first cycle in which ready_o is sampled high; the bench compares all four outputs on every falling edge from there. Mode changes act on the outputs at once. The resume from power-down is the one case where the first position seen is 1, and the bench restarts its model at that value. The fall of ready_o after a load is checked one edge after the pulse, and the rise is checked against the computed conversion bound.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;
  localparam int LW = 16;
  localparam logic [LW-1:0] SEED = '1;
  localparam int NREG = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_RUN} seq_e;

  // one step: shift left, feed back taps 15,4,2,1
  function automatic logic [LW-1:0] lfsr_next(input logic [LW-1:0] s);
    return {s[LW-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
  endfunction
endpackage

// File: rtl/lfsr_cnt_conv.sv
module lfsr_cnt_conv
  import lfsr_vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [LW-1:0] state_o
);
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      rem_q   <= '0;
      state_o <= SEED;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        state_o <= SEED;
        rem_q   <= count_i;
        busy_o  <= 1'b1;
      end else if (busy_o) begin
        if (rem_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          state_o <= lfsr_next(state_o);
          rem_q   <= rem_q - 1'b1;
        end
      end
    end
  end

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && !done_o);
  p_done_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  p_rem_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_i && rem_q != '0 |=> rem_q == $past(rem_q) - 1'b1);
endmodule

// File: rtl/lfsr_axis.sv
module lfsr_axis
  import lfsr_vtg_pkg::*;
#(
  parameter bit LOOKAHEAD = 1'b0,  // compare successor state for terminal
  parameter int NWIN = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     adv_i,
  input  logic [LW-1:0]            end_i,
  input  logic [NWIN-1:0][LW-1:0]  on_i,
  input  logic [NWIN-1:0][LW-1:0]  off_i,
  output logic                     wrap_o,
  output logic [NWIN-1:0]          flag_o
);
  logic [LW-1:0] st_q;
  logic          hit;

  generate
    if (LOOKAHEAD) begin : g_ahead
      assign hit = (lfsr_next(st_q) == end_i);
    end else begin : g_now
      assign hit = (st_q == end_i);
    end
  endgenerate

  assign wrap_o = adv_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= SEED;
    else if (clr_i)  st_q <= SEED;
    else if (adv_i)  st_q <= hit ? SEED : lfsr_next(st_q);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_o[w] <= 1'b0;
      else if (clr_i)   flag_o[w] <= 1'b0;
      else if (adv_i) begin
        if (st_q == on_i[w])       flag_o[w] <= 1'b1;
        else if (st_q == off_i[w]) flag_o[w] <= 1'b0;
      end
    end
  end

  p_wrap_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !clr_i |=> st_q == SEED);
  p_step_moves_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !hit && !clr_i |=> st_q != $past(st_q));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> st_q == SEED && flag_o == '0);
endmodule

// File: rtl/lfsr_vtg.sv
module lfsr_vtg
  import lfsr_vtg_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] htotal_i,
  input  logic [TW-1:0] hactive_i,
  input  logic [TW-1:0] hsync_start_i,
  input  logic [TW-1:0] hsync_len_i,
  input  logic [TW-1:0] vtotal_i,
  input  logic [TW-1:0] vactive_i,
  input  logic [TW-1:0] vsync_start_i,
  input  logic [TW-1:0] vsync_len_i,
  input  logic [1:0]    blank_mode_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          blank_o,
  output logic          ready_o
);
  localparam logic [LW-1:0] HSS_ENC = lfsr_next(SEED);  // fixed sync start = 1
  localparam int IW = $clog2(NREG);

  function automatic logic [LW-1:0] ext(input logic [TW-1:0] v);
    return LW'(v);
  endfunction

  seq_e                     state_q;
  logic [IW-1:0]            idx_q;
  logic                     pending_q;
  logic [NREG-1:0][LW-1:0]  enc_q;
  logic [7:0][TW-1:0]       cfg_q;
  logic [LW-1:0]            conv_cnt, conv_st;
  logic                     conv_busy, conv_done;

  // binary position value for each slot
  always_comb begin
    unique case (idx_q)
      3'd0:    conv_cnt = ext(cfg_q[0]) - 16'd1;
      3'd1:    conv_cnt = ext(cfg_q[3]) + 16'd1;
      3'd2:    conv_cnt = ext(cfg_q[0]) - ext(cfg_q[2]);
      3'd3:    conv_cnt = ext(cfg_q[0]) - ext(cfg_q[2]) + ext(cfg_q[1]);
      3'd4:    conv_cnt = ext(cfg_q[4]);
      3'd5:    conv_cnt = ext(cfg_q[7]);
      3'd6:    conv_cnt = ext(cfg_q[4]) - ext(cfg_q[6]);
      default: conv_cnt = ext(cfg_q[4]) - ext(cfg_q[6]) + ext(cfg_q[5]);
    endcase
  end

  lfsr_cnt_conv u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pending_q),
    .count_i (conv_cnt),
    .busy_o  (conv_busy),
    .done_o  (conv_done),
    .state_o (conv_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      pending_q <= 1'b0;
      enc_q     <= '{default: SEED};
      cfg_q     <= '0;
    end else if (load_i) begin
      cfg_q     <= {vsync_len_i, vsync_start_i, vactive_i, vtotal_i,
                    hsync_len_i, hsync_start_i, hactive_i, htotal_i};
      state_q   <= ST_CONV;
      idx_q     <= '0;
      pending_q <= 1'b1;
    end else if (state_q == ST_CONV) begin
      if (pending_q) begin
        pending_q <= 1'b0;
      end else if (conv_done) begin
        enc_q[idx_q] <= conv_st;
        if (idx_q == IW'(NREG - 1)) begin
          state_q <= ST_RUN;
        end else begin
          idx_q     <= idx_q + 1'b1;
          pending_q <= 1'b1;
        end
      end
    end
  end

  logic run, pd, hwrap, vwrap;
  logic [1:0] hflag, vflag;

  assign run = (state_q == ST_RUN);
  assign pd  = blank_mode_i[1];

  lfsr_axis #(.LOOKAHEAD(1'b0), .NWIN(2)) u_hax (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~run | pd),
    .adv_i  (run & ~pd),
    .end_i  (enc_q[0]),
    .on_i   ({enc_q[2], HSS_ENC}),
    .off_i  ({enc_q[3], enc_q[1]}),
    .wrap_o (hwrap),
    .flag_o (hflag)
  );

  // vertical terminal is vtotal; successor compare gives vtotal lines
  lfsr_axis #(.LOOKAHEAD(1'b1), .NWIN(2)) u_vax (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~run | pd),
    .adv_i  (hwrap),
    .end_i  (enc_q[4]),
    .on_i   ({enc_q[6], SEED}),
    .off_i  ({enc_q[7], enc_q[5]}),
    .wrap_o (vwrap),
    .flag_o (vflag)
  );

  assign hsync_o = run & ~pd & hflag[0];
  assign vsync_o = run & ~pd & vflag[0];
  assign de_o    = run & (blank_mode_i == 2'b00) & hflag[1] & vflag[1];
  assign blank_o = ~de_o;
  assign ready_o = run;

  p_load_drops_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o);
  p_start_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !hsync_o && !vsync_o && !de_o);
  p_vwrap_on_hwrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vwrap |-> hwrap);
  p_conv_idle_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !load_i |-> !conv_busy);
endmodule

// File: tb/lfsr_vtg_bench.sv
`timescale 1ns/1ps
module lfsr_vtg_bench;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [TW-1:0] ht, ha, hss, hsl, vt, va, vss, vsl;
  logic [1:0] mode = 2'b00;
  logic hs, vs, de, bl, rdy;

  int n_chk = 0;
  int n_bad = 0;
  int HT, HA, HSS, HSL, VT, VA, VSS, VSL;

  always #10 clk = ~clk;

  lfsr_vtg #(.TW(TW)) u_lfsr_vtg (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .htotal_i(ht), .hactive_i(ha), .hsync_start_i(hss), .hsync_len_i(hsl),
    .vtotal_i(vt), .vactive_i(va), .vsync_start_i(vss), .vsync_len_i(vsl),
    .blank_mode_i(mode),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .blank_o(bl), .ready_o(rdy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int a, b, c, d, e, f, g, h);
    HT = a; HA = b; HSS = c; HSL = d; VT = e; VA = f; VSS = g; VSL = h;
    ht = TW'(a); ha = TW'(b); hss = TW'(c); hsl = TW'(d);
    vt = TW'(e); va = TW'(f); vss = TW'(g); vsl = TW'(h);
  endtask

  // pulse load, then wait for ready; returns at the negedge where h = 0
  task automatic program_cfg();
    int bound, n;
    bound = (HT - 1) + (HSL + 1) + (HT - HSS) + (HT - HSS + HA)
          + VT + VSL + (VT - VSS) + (VT - VSS + VA) + 28;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R12 ready drops after load", int'(rdy), 0);
    n = 1;
    while (!rdy && n <= bound) begin
      @(negedge clk);
      n++;
    end
    chk("R2 ready within conversion bound", int'(rdy), 1);
  endtask

  // compare every cycle against the arithmetic model
  task automatic run_check(inout int t, input int cycles, input bit blanked);
    int last_hr, last_vr;
    bit ph, pv;
    last_hr = -1; last_vr = -1; ph = 1'b1; pv = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      int h, l, ds, vds;
      bit e_hs, e_vs, e_hde, e_vde, e_de;
      h = t % HT;
      l = (t / HT) % VT;
      ds = HT - HSS;
      vds = VT - VSS;
      e_hs  = (h >= 2) && (h <= HSL + 1);
      e_hde = (h >= ds + 1) && (h <= ds + HA);
      e_vs  = (l >= 1) && (l <= VSL);
      e_vde = (l >= vds + 1) && (l <= vds + VA);
      e_de  = !blanked && e_hde && e_vde;
      chk("R4 hsync", int'(hs), int'(e_hs));
      chk("R7 vsync", int'(vs), int'(e_vs));
      chk(blanked ? "R9 de blanked" : "R5 R8 de window", int'(de), int'(e_de));
      chk("R11 blank inverse", int'(bl), int'(!e_de));
      if (hs && !ph) begin
        if (last_hr >= 0) chk("R3 line period", t - last_hr, HT);
        last_hr = t;
      end
      if (vs && !pv) begin
        if (last_vr >= 0) chk("R6 frame period", t - last_vr, HT * VT);
        last_vr = t;
      end
      ph = hs; pv = vs;
      t++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    set_cfg(24, 16, 18, 3, 10, 6, 7, 2);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hsync in reset", int'(hs), 0);
    chk("R1 ready in reset", int'(rdy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 hsync idle", int'(hs), 0);
    chk("R1 vsync idle", int'(vs), 0);
    chk("R1 de idle", int'(de), 0);
    chk("R1 blank idle", int'(bl), 1);
    chk("R1 ready idle", int'(rdy), 0);

    // config A
    program_cfg();
    t = 0;
    run_check(t, 2 * 24 * 10, 1'b0);

    // R9 blanked video, counters keep running
    mode = 2'b01;
    run_check(t, 150, 1'b1);
    mode = 2'b00;
    run_check(t, 150, 1'b0);

    // R10 power-down
    mode = 2'b10;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R10 hsync off", int'(hs), 0);
      chk("R10 vsync off", int'(vs), 0);
      chk("R10 de off", int'(de), 0);
    end
    mode = 2'b00;
    @(negedge clk);
    t = 1;
    run_check(t, 2 * 24 * 10, 1'b0);

    // R12 reload while scanning, boundary windows ending at last position
    set_cfg(16, 9, 10, 1, 6, 2, 3, 1);
    program_cfg();
    t = 0;
    run_check(t, 3 * 16 * 6, 1'b0);

    // larger config
    set_cfg(40, 30, 34, 4, 12, 8, 10, 2);
    program_cfg();
    t = 0;
    run_check(t, 2 * 40 * 12, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule